// File: doc/BRIEF.md
# SDRAM Single-Bank Write Path with Precharge Cut-Off

This block models the write side of one synchronous DRAM bank at the command level. On each clock it takes one command: idle, open row, write, or close row (precharge). There is also a column address and an input data word. A write starts an eight-beat burst. The first word is taken on the write cycle itself, and one further word is taken on each later cycle. The column steps upward and wraps inside its eight-aligned block.

A precharge that arrives in the middle of a burst ends the burst. The word presented with the precharge is dropped, so the last word kept is the one from the cycle before. After a precharge, the bank stays closed for a recovery window. The window is the data-to-precharge delay plus the precharge period, and it is counted from the last data cycle. Commands that break these rules are discarded, and a violation flag pulses for one cycle. A combinational debug port reads any stored word, so the committed beats can be checked.

Top module: `sdram_wr_bank`

## Requirements
- R1: After reset, `active_o` and `viol_o` are 0.
- R2: A write command (`cmd_i` = 2) while the bank is closed stores nothing and sets `viol_o` on the following cycle.
- R3: An open command (`cmd_i` = 1) on a closed bank with recovery complete sets `active_o` on the following cycle.
- R4: A write on an open bank stores `din_i` at `col_i` in that cycle and then stores one word per cycle for 7 more cycles while `cmd_i` is idle (0) or open (1).
- R5: Beat k of a burst goes to column {col_i[COL_W-1:3], col_i[2:0]+k}, wrapping within the eight-aligned block.
- R6: A precharge (`cmd_i` = 3) ends the burst and closes the bank. The word on that cycle and all remaining beats are not stored.
- R7: After a precharge in cycle P, an open command before cycle P+TDPL+TRP-1 is ignored and flagged. At that cycle it is accepted. P-1 is the last data cycle.
- R8: An open command while the bank is already open is flagged and ignored: the bank stays open and a running burst keeps storing.
- R9: `viol_o` is high for exactly one cycle per offending command and is low after a legal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | 0 idle, 1 open row, 2 write, 3 precharge |
| col_i | input | COL_W | Start column of a write |
| din_i | input | DATA_W | Write data for the current cycle |
| dbg_addr_i | input | COL_W | Debug read address |
| dbg_data_o | output | DATA_W | Stored word at `dbg_addr_i` (combinational) |
| active_o | output | 1 | Bank open |
| viol_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
The assertions assume that `cmd_i` always carries one of the four defined codes and is stable around the rising edge. They also assume that a violation can only come from an open or write command. The stimulus drives every input on the falling edge and uses only the four encodings. It reaches each rejected case on purpose: a write while closed, an open during recovery, and an open during a running burst. A terminated burst overwrites a block that was filled earlier, so the debug port shows which beats were kept and which were dropped.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;
endpackage

// File: rtl/sdram_wr_ctrl.sv
module sdram_wr_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COL_W  = 5,
    parameter int BL     = 8,
    parameter int TDPL   = 1,
    parameter int TRP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              we_o,
    output logic [COL_W-1:0]  waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              active_o,
    output logic              viol_o
);
    localparam int BL_LG = $clog2(BL);
    localparam int TDAL  = TDPL + TRP;
    localparam int RC_W  = $clog2(TDAL + 1);
    localparam int LD    = (TDAL >= 2) ? TDAL - 2 : 0;

    typedef struct packed {
        logic             active;
        logic [BL_LG:0]   left;
        logic [COL_W-1:0] addr;
        logic [RC_W-1:0]  rcnt;
        logic             viol;
    } st_t;

    st_t  st_d, st_q;
    cmd_e cmd;

    function automatic logic [COL_W-1:0] nxt(input logic [COL_W-1:0] a);
        logic [COL_W-1:0] r;
        r = a;
        r[BL_LG-1:0] = a[BL_LG-1:0] + 1'b1;
        return r;
    endfunction

    always_comb begin
        cmd     = cmd_e'(cmd_i);
        st_d    = st_q;
        st_d.viol = 1'b0;
        we_o    = 1'b0;
        waddr_o = st_q.addr;
        wdata_o = din_i;
        if (st_q.rcnt != '0) begin
            st_d.rcnt = st_q.rcnt - 1'b1;
        end
        // running burst keeps taking beats unless a write or precharge arrives
        if ((cmd == CMD_NOP || cmd == CMD_ACT) && st_q.left != '0) begin
            we_o      = 1'b1;
            st_d.left = st_q.left - 1'b1;
            st_d.addr = nxt(st_q.addr);
        end
        case (cmd)
            CMD_ACT: begin
                if (st_q.active || st_q.rcnt != '0) begin
                    st_d.viol = 1'b1;
                end else begin
                    st_d.active = 1'b1;
                end
            end
            CMD_WR: begin
                if (!st_q.active) begin
                    st_d.viol = 1'b1;
                end else begin
                    we_o      = 1'b1;
                    waddr_o   = col_i;
                    st_d.left = (BL_LG + 1)'(BL - 1);
                    st_d.addr = nxt(col_i);
                end
            end
            CMD_PRE: begin
                if (st_q.active) begin
                    st_d.active = 1'b0;
                    st_d.left   = '0;
                    st_d.rcnt   = RC_W'(LD);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign viol_o   = st_q.viol;
endmodule

// File: rtl/sdram_wr_array.sv
module sdram_wr_array #(
    parameter int DATA_W = 8,
    parameter int COL_W  = 5
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [COL_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [COL_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sdram_wr_bank.sv
module sdram_wr_bank #(
    parameter int DATA_W = 8,
    parameter int COL_W  = 5,
    parameter int BL     = 8,
    parameter int TDPL   = 1,
    parameter int TRP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [COL_W-1:0]  dbg_addr_i,
    output logic [DATA_W-1:0] dbg_data_o,
    output logic              active_o,
    output logic              viol_o
);
    logic              wr_en;
    logic [COL_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;

    sdram_wr_ctrl #(
        .DATA_W(DATA_W), .COL_W(COL_W), .BL(BL), .TDPL(TDPL), .TRP(TRP)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd_i),
        .col_i   (col_i),
        .din_i   (din_i),
        .we_o    (wr_en),
        .waddr_o (wr_addr),
        .wdata_o (wr_data),
        .active_o(active_o),
        .viol_o  (viol_o)
    );

    sdram_wr_array #(
        .DATA_W(DATA_W), .COL_W(COL_W)
    ) u_array (
        .clk    (clk),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(wr_data),
        .raddr_i(dbg_addr_i),
        .rdata_o(dbg_data_o)
    );
endmodule

// File: rtl/sdram_wr_bank_chk.sv
module sdram_wr_bank_chk
    import sdram_wr_pkg::*;
#(
    parameter int TDPL = 1,
    parameter int TRP  = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_i,
    input logic       mem_we,
    input logic       active_o,
    input logic       viol_o
);
    a_r2_write_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WR && !active_o) |=> viol_o);

    a_r8_act_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && active_o) |=> (viol_o && active_o));

    a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE) |=> !active_o);

    a_r6_pre_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE) |-> !mem_we);

    a_r4_write_open: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> active_o);

    a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(cmd_i) == CMD_ACT || $past(cmd_i) == CMD_WR));

    generate
        if (TDPL + TRP >= 3) begin : g_rec
            a_r7_early_act: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_i == CMD_PRE && active_o) |=>
                    ((cmd_i == CMD_ACT) |=> (viol_o && !active_o)));
        end
    endgenerate
endmodule

bind sdram_wr_bank sdram_wr_bank_chk #(.TDPL(TDPL), .TRP(TRP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd_i),
    .mem_we  (wr_en),
    .active_o(active_o),
    .viol_o  (viol_o)
);

// File: tb/sdram_wr_bank_tb.sv
`timescale 1ns/1ps
module sdram_wr_bank_tb;
    localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, WR = 2'd2, PRE = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = NOP;
    logic [4:0] col = '0;
    logic [7:0] din = '0;
    logic [4:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic       active, viol;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit    vq[$];
    string tq[$];

    always #2.5 clk = ~clk;

    sdram_wr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col), .din_i(din),
        .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data),
        .active_o(active), .viol_o(viol)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one command and queues the expected violation flag
    task automatic step(input logic [1:0] c, input int cl, input int d,
                        input bit ev, input string tag);
        cmd = c;
        col = cl[4:0];
        din = d[7:0];
        vq.push_back(ev);
        tq.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compares the flag just after each edge
    always @(posedge clk) begin
        #1;
        if (vq.size() > 0) begin
            bit    e;
            string t;
            e = vq.pop_front();
            t = tq.pop_front();
            chk(t, {7'd0, viol}, {7'd0, e});
        end
    end

    task automatic mem(input int a, input int exp, input string tag);
        dbg_addr = a[4:0];
        #0.5;
        chk(tag, dbg_data, exp[7:0]);
    endtask

    task automatic burst(input int c0, input int d0);
        step(WR, c0, d0, 0, "R4 burst start");
        for (int k = 1; k < 8; k++) step(NOP, 0, d0 + k, 0, "R4 burst beat");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 active", {7'd0, active}, 8'd0);
        chk("R1 viol", {7'd0, viol}, 8'd0);

        step(WR, 0, 8'h77, 1, "R2 write closed");
        step(NOP, 0, 0, 0, "R9 pulse ends");
        chk("R2 still closed", {7'd0, active}, 8'd0);

        step(ACT, 0, 0, 0, "R3 open");
        chk("R3 active", {7'd0, active}, 8'd1);

        burst(2, 8'h10);
        burst(8, 8'h40);

        // open during a running burst: flagged, burst continues
        step(WR, 16, 8'h50, 0, "R8 burst start");
        step(ACT, 0, 8'h51, 1, "R8 open while open");
        for (int k = 2; k < 8; k++) step(NOP, 0, 8'h50 + k, 0, "R9 burst beat");
        chk("R8 still open", {7'd0, active}, 8'd1);

        // terminated burst over the filled block
        step(WR, 13, 8'hA0, 0, "R6 start");
        step(NOP, 0, 8'hA1, 0, "R6 beat");
        step(NOP, 0, 8'hA2, 0, "R6 beat");
        step(NOP, 0, 8'hA3, 0, "R6 beat");
        step(NOP, 0, 8'hA4, 0, "R6 beat");
        step(PRE, 0, 8'hEE, 0, "R6 precharge");
        chk("R6 closed", {7'd0, active}, 8'd0);
        step(ACT, 0, 8'hEF, 1, "R7 early open");
        chk("R7 stays closed", {7'd0, active}, 8'd0);
        step(ACT, 0, 0, 0, "R7 open on time");
        chk("R7 reopened", {7'd0, active}, 8'd1);

        step(PRE, 0, 0, 0, "R6 close again");
        step(NOP, 0, 0, 0, "R9 idle");
        step(NOP, 0, 0, 0, "R9 idle");
        step(WR, 8, 8'h99, 1, "R2 write closed late");
        step(NOP, 0, 0, 0, "R9 idle");

        mem(2, 8'h10, "R5 col2");
        mem(7, 8'h15, "R5 col7");
        mem(0, 8'h16, "R5 wrap col0");
        mem(1, 8'h17, "R5 wrap col1");
        mem(15, 8'hA2, "R4 col15");
        mem(17, 8'h51, "R8 beat kept");
        mem(23, 8'h57, "R4 last beat");
        mem(13, 8'hA0, "R6 first beat");
        mem(8, 8'hA3, "R2 col8 untouched");
        mem(9, 8'hA4, "R6 last kept");
        mem(10, 8'h42, "R6 pre data dropped");
        mem(11, 8'h43, "R6 beat not written");
        mem(12, 8'h44, "R6 beat not written");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule